// File: doc/BRIEF.md
# Paged Open-Drain Digital I/O Controller with Edge Interrupts

This block is a byte-wide register front end for 48 open-drain digital lines, grouped as six 8-bit ports. A host writes a port register to choose which lines sink current: a 1 pulls the pin low and a 0 releases it. Released lines can be used as inputs. Reading a port returns the inverted, synchronized level of its pins, so a pin resting high reads as 0. Pads and pull-ups are outside the block. Each line is modelled as an output enable that means "sink" plus an input level.

The three lowest ports can also raise interrupts. Each of their 24 lines has a polarity bit that picks a rising or a falling edge, an enable bit, and a sticky identification bit. These three register banks share one three-byte window and are chosen with a page field. A summary register shows which interrupt-capable ports hold a latched edge, and a single request output is raised while any identification bit is set. The host services an interrupt by reading the identification bank and writing zeros to the bits it has handled.

The register decode has no sequencing. Every access completes in the cycle in which it is presented. For this reason the block has no state machine: the page field and the per-bit interrupt latches are the only state that steers behaviour.

Top module: `dio_paged_ctrl`

## Requirements
- R1: After reset, every port register, polarity, enable and identification bit is 0, the page field and all lock bits read as 0, and `irq` is low.
- R2: A write to offset p (0–5) whose lock bit is clear sets `pin_oe[8p+7:8p]` to the written byte from the next clock edge on. This works whatever page is selected.
- R3: A read of offset p (0–5) returns the bitwise inverse of `pin_in[8p+7:8p]` as sampled through a two-flop synchronizer, so the read follows the pin two clock edges after a change.
- R4: Offset 7 holds the page in bits 7:6 and one lock bit per port in bits 5:0 (bit p locks port p). A write to a locked port's data register leaves that port unchanged, and unlocked ports still accept writes.
- R5: Offsets 8, 9 and 10 address ports 0, 1 and 2. On page 1 they reach the polarity registers, on page 2 the enable registers, and on page 3 the identification registers. On page 0 they read as 0 and ignore writes.
- R6: A polarity bit of 1 detects a 0→1 transition of the synchronized pin, and a polarity bit of 0 detects a 1→0 transition. A transition in the other direction latches nothing.
- R7: A transition on a line whose enable bit is 0 never sets its identification bit.
- R8: Identification bits stay set until cleared. A write on page 3 clears each bit written as 0 and keeps each bit written as 1.
- R9: Offset 6 bit k (k = 0..2) is 1 while any identification bit of port k is set. `irq` is high exactly while any identification bit is set.
- R10: Ports 3 to 5 never set a pending bit or raise `irq`, and offset 6 bits 7:3 always read 0.
- R11: An edge detected in the same cycle as a clearing write to its identification register is kept: the new bit is set after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 48 | Pin levels, asynchronous |
| pin_oe | output | 48 | 1 = sink the pin low, 0 = release it |
| irq | output | 1 | Interrupt request, OR of all identification bits |

## Verification
A wrong page field shows up at once: the next read of offsets 8 to 10 returns the wrong bank, or 0 on page 0. A corrupted lock bit shows on the first write to that port, because `pin_oe` changes or fails to change one edge later. Errors in polarity, enable or synchronizer delay show three edges after a pin change, when `irq` rises and the pending and identification registers read back. A clear that is lost, or one that wipes too much, shows on the next read of the identification bank and on `irq` in the cycle after the write.

// File: rtl/dio_pkg.sv
package dio_pkg;
    // Bank selected by the page field for the shared interrupt window
    typedef enum logic [1:0] {
        PG_DATA = 2'd0,
        PG_POL  = 2'd1,
        PG_ENA  = 2'd2,
        PG_ID   = 2'd3
    } page_e;

    localparam int PAGE_BITS = 2;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= d;
            stable_q <= meta_q;
        end
    end

    assign q = stable_q;
endmodule

// File: rtl/dio_edge_unit.sv
module dio_edge_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] en,
    input  logic         clr_we,
    input  logic [W-1:0] clr_keep,
    output logic [W-1:0] id_q
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] fall;
    logic [W-1:0] hit;
    logic [W-1:0] kept;

    always_comb begin
        rise = lvl & ~prev_q;
        fall = ~lvl & prev_q;
        hit  = en & ((pol & rise) | (~pol & fall));
        kept = clr_we ? (id_q & clr_keep) : id_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            id_q   <= '0;
        end else begin
            prev_q <= lvl;
            id_q   <= kept | hit;   // a fresh edge survives a clear
        end
    end
endmodule

// File: rtl/dio_paged_ctrl.sv
module dio_paged_ctrl
    import dio_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int BYTE_W    = 8,
    parameter int INT_PORTS = 3,
    parameter int ADDR_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [BYTE_W-1:0]           bus_wdata,
    output logic [BYTE_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*BYTE_W-1:0] pin_in,
    output logic [NUM_PORTS*BYTE_W-1:0] pin_oe,
    output logic                        irq
);
    localparam int LINES     = NUM_PORTS * BYTE_W;
    localparam int INT_LINES = INT_PORTS * BYTE_W;
    localparam logic [ADDR_W-1:0] OFF_PEND = ADDR_W'(NUM_PORTS);
    localparam logic [ADDR_W-1:0] OFF_PAGE = ADDR_W'(NUM_PORTS + 1);
    localparam int OFF_BANK  = NUM_PORTS + 2;

    logic [LINES-1:0]     oe_q;
    logic [LINES-1:0]     lvl_s;
    logic [NUM_PORTS-1:0] lock_q;
    page_e                page_q;
    logic [INT_LINES-1:0] pol_q;
    logic [INT_LINES-1:0] en_q;
    logic [INT_LINES-1:0] id_flat;
    logic [INT_PORTS-1:0] port_pend;
    logic [INT_PORTS-1:0] clr_we;
    logic [INT_PORTS-1:0] wr_bank;
    logic                 wr_page;

    // Write decode
    always_comb begin
        wr_page = bus_wr && (bus_addr == OFF_PAGE);
        for (int k = 0; k < INT_PORTS; k++) begin
            wr_bank[k] = bus_wr && (bus_addr == ADDR_W'(OFF_BANK + k));
            clr_we[k]  = wr_bank[k] && (page_q == PG_ID);
        end
    end

    // Port data registers, blocked by their lock bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= '0;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (bus_wr && (bus_addr == ADDR_W'(p)) && !lock_q[p])
                    oe_q[p*BYTE_W +: BYTE_W] <= bus_wdata;
            end
        end
    end

    // Page field and lock bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= PG_DATA;
            lock_q <= '0;
        end else if (wr_page) begin
            page_q <= page_e'(bus_wdata[BYTE_W-1 -: PAGE_BITS]);
            lock_q <= bus_wdata[NUM_PORTS-1:0];
        end
    end

    // Paged polarity and enable banks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= '0;
            en_q  <= '0;
        end else begin
            for (int k = 0; k < INT_PORTS; k++) begin
                if (wr_bank[k] && page_q == PG_POL)
                    pol_q[k*BYTE_W +: BYTE_W] <= bus_wdata;
                if (wr_bank[k] && page_q == PG_ENA)
                    en_q[k*BYTE_W +: BYTE_W] <= bus_wdata;
            end
        end
    end

    dio_sync #(.W(LINES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (lvl_s)
    );

    for (genvar k = 0; k < INT_PORTS; k++) begin : g_edge
        dio_edge_unit #(.W(BYTE_W)) edge_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (lvl_s[k*BYTE_W +: BYTE_W]),
            .pol     (pol_q[k*BYTE_W +: BYTE_W]),
            .en      (en_q[k*BYTE_W +: BYTE_W]),
            .clr_we  (clr_we[k]),
            .clr_keep(bus_wdata),
            .id_q    (id_flat[k*BYTE_W +: BYTE_W])
        );
        assign port_pend[k] = |id_flat[k*BYTE_W +: BYTE_W];
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == ADDR_W'(p))
                bus_rdata = ~lvl_s[p*BYTE_W +: BYTE_W];
        end
        if (bus_addr == OFF_PEND)
            bus_rdata[INT_PORTS-1:0] = port_pend;
        if (bus_addr == OFF_PAGE) begin
            bus_rdata[BYTE_W-1 -: PAGE_BITS] = page_q;
            bus_rdata[NUM_PORTS-1:0]         = lock_q;
        end
        for (int k = 0; k < INT_PORTS; k++) begin
            if (bus_addr == ADDR_W'(OFF_BANK + k)) begin
                unique case (page_q)
                    PG_POL:  bus_rdata = pol_q[k*BYTE_W +: BYTE_W];
                    PG_ENA:  bus_rdata = en_q[k*BYTE_W +: BYTE_W];
                    PG_ID:   bus_rdata = id_flat[k*BYTE_W +: BYTE_W];
                    PG_DATA: bus_rdata = '0;
                endcase
            end
        end
    end

    assign pin_oe = oe_q;
    assign irq    = |port_pend;
endmodule

// File: rtl/dio_paged_chk.sv
module dio_paged_chk #(
    parameter int NUM_PORTS = 6,
    parameter int BYTE_W    = 8,
    parameter int INT_PORTS = 3,
    parameter int ADDR_W    = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_wr,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [BYTE_W-1:0]             bus_wdata,
    input logic [BYTE_W-1:0]             bus_rdata,
    input logic [NUM_PORTS*BYTE_W-1:0]   pin_oe,
    input logic                          irq,
    input logic [NUM_PORTS-1:0]          lock_q,
    input logic [INT_PORTS*BYTE_W-1:0]   id_flat,
    input logic [INT_PORTS*BYTE_W-1:0]   en_q
);
    localparam logic [ADDR_W-1:0] OFF_PEND = ADDR_W'(NUM_PORTS);

    p_irq_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_PEND) |-> (irq == (|bus_rdata)));

    p_upper_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_PEND) |-> (bus_rdata[BYTE_W-1:INT_PORTS] == '0));

    p_id_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((id_flat & ~$past(id_flat) & ~$past(en_q)) == '0));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        p_port_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(p) && !lock_q[p])
            |=> (pin_oe[p*BYTE_W +: BYTE_W] == $past(bus_wdata)));

        p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(p) && lock_q[p])
            |=> $stable(pin_oe[p*BYTE_W +: BYTE_W]));
    end
endmodule

bind dio_paged_ctrl dio_paged_chk #(
    .NUM_PORTS(NUM_PORTS),
    .BYTE_W   (BYTE_W),
    .INT_PORTS(INT_PORTS),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .lock_q   (lock_q),
    .id_flat  (id_flat),
    .en_q     (en_q)
);

// File: tb/dio_paged_ctrl_tb_top.sv
module dio_paged_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] pin_in = '0;
    logic [47:0] pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dio_paged_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .irq(irq)
    );

    // {port, write byte, pin byte}; expected sink = write byte, readback = ~pin byte
    localparam logic [23:0] VEC [6] = '{
        {8'd0, 8'hA5, 8'h00},
        {8'd1, 8'h3C, 8'hFF},
        {8'd2, 8'h01, 8'h80},
        {8'd3, 8'hFF, 8'h5A},
        {8'd4, 8'h00, 8'h0F},
        {8'd5, 8'h81, 8'hC3}
    };

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [7:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state
        check("R1 pin_oe", pin_oe, 48'h0);
        check("R1 irq", {47'h0, irq}, 48'h0);
        rd(4'd7, r); check("R1 page/lock", {40'h0, r}, 48'h0);
        rd(4'd6, r); check("R1 pending", {40'h0, r}, 48'h0);

        // R2/R3 table walk
        for (int i = 0; i < 6; i++) begin
            int p;
            p = int'(VEC[i][23:16]);
            pin_in = 48'h0;
            pin_in[p*8 +: 8] = VEC[i][7:0];
            wr(4'(p), VEC[i][15:8]);
            settle(2);
            check($sformatf("R2 port%0d sink", p), {40'h0, pin_oe[p*8 +: 8]}, {40'h0, VEC[i][15:8]});
            rd(4'(p), r);
            check($sformatf("R3 port%0d readback", p), {40'h0, r}, {40'h0, ~VEC[i][7:0]});
        end
        pin_in = 48'h0000_0000_0002;   // line 1 rests high for the falling test
        settle(3);

        // R4 lock
        wr(4'd7, 8'h04);
        wr(4'd2, 8'h77);
        check("R4 locked port held", {40'h0, pin_oe[23:16]}, 48'h01);
        wr(4'd1, 8'h66);
        check("R4 unlocked port written", {40'h0, pin_oe[15:8]}, 48'h66);
        rd(4'd7, r); check("R4 lock readback", {40'h0, r}, 48'h04);
        wr(4'd7, 8'h00);
        wr(4'd2, 8'h77);
        check("R4 unlocked again", {40'h0, pin_oe[23:16]}, 48'h77);

        // R5 paging
        wr(4'd8, 8'h55);                 // page 0: ignored
        rd(4'd8, r); check("R5 page0 reads zero", {40'h0, r}, 48'h0);
        wr(4'd7, 8'h40);
        rd(4'd8, r); check("R5 page0 write ignored", {40'h0, r}, 48'h0);
        wr(4'd8, 8'h01);                 // port0 bit0 rising, others falling
        wr(4'd9, 8'h00);
        wr(4'd7, 8'h80);
        rd(4'd8, r); check("R5 enable bank reset", {40'h0, r}, 48'h0);
        wr(4'd8, 8'h0B);
        wr(4'd9, 8'h01);
        wr(4'd7, 8'h40);
        rd(4'd8, r); check("R5 polarity readback", {40'h0, r}, 48'h01);
        wr(4'd0, 8'h12);
        check("R5 data port on page1", {40'h0, pin_oe[7:0]}, 48'h12);
        rd(4'd0, r); check("R5 readback on page1", {40'h0, r}, 48'hFD);

        // R6/R7 edges
        wr(4'd7, 8'hC0);
        rd(4'd8, r); check("R6 id clear before edges", {40'h0, r}, 48'h0);
        @(negedge clk);
        pin_in[0] = 1'b1; pin_in[1] = 1'b0; pin_in[2] = 1'b1;
        settle(4);
        rd(4'd8, r); check("R6 R7 rise, fall, disabled line", {40'h0, r}, 48'h03);
        check("R9 irq high", {47'h0, irq}, 48'h1);
        rd(4'd6, r); check("R9 pending port0", {40'h0, r}, 48'h01);
        @(negedge clk); pin_in[8] = 1'b1;    // rising on falling-polarity line
        settle(4);
        rd(4'd9, r); check("R6 wrong direction ignored", {40'h0, r}, 48'h0);
        @(negedge clk); pin_in[8] = 1'b0;
        settle(4);
        rd(4'd9, r); check("R6 falling latched", {40'h0, r}, 48'h01);
        rd(4'd6, r); check("R9 pending ports0,1", {40'h0, r}, 48'h03);

        // R8 sticky and selective clear
        wr(4'd8, 8'h02);
        rd(4'd8, r); check("R8 partial clear", {40'h0, r}, 48'h02);
        check("R8 irq still high", {47'h0, irq}, 48'h1);
        wr(4'd8, 8'h00);
        wr(4'd9, 8'h00);
        rd(4'd8, r); check("R8 cleared", {40'h0, r}, 48'h0);
        check("R9 irq low", {47'h0, irq}, 48'h0);
        rd(4'd6, r); check("R9 pending clear", {40'h0, r}, 48'h0);

        // R10 upper ports cannot interrupt
        @(negedge clk); pin_in[24] = 1'b1; pin_in[40] = 1'b1;
        settle(4);
        @(negedge clk); pin_in[24] = 1'b0; pin_in[40] = 1'b0;
        settle(4);
        check("R10 irq quiet", {47'h0, irq}, 48'h0);
        rd(4'd6, r); check("R10 pending quiet", {40'h0, r}, 48'h0);

        // R11 edge coincident with clear
        @(negedge clk); pin_in[0] = 1'b0;
        settle(4);
        @(negedge clk); pin_in[0] = 1'b1;    // rising on bit0
        settle(4);
        rd(4'd8, r); check("R11 setup", {40'h0, r}, 48'h01);
        @(negedge clk); pin_in[3] = 1'b1;    // rising on falling line: no set
        settle(4);
        @(negedge clk); pin_in[3] = 1'b0;    // falling, detected at third edge
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd8; bus_wdata = 8'h00;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(4'd8, r); check("R11 new edge survives clear", {40'h0, r}, 48'h08);

        done = 1'b1;
        report();
    end
endmodule